// File: doc/BRIEF.md
# Three-Stage Watchdog Timer

This block guards a running system with a countdown that firmware must restart before it runs out. Each time the countdown runs out, the watchdog moves one step further through an escalation ladder. The first expiry raises a first interrupt. The second expiry raises a second interrupt. The third expiry requests a soft reset. Each stage gets a fresh countdown of the same length.

Firmware programs the block through a single 64-bit configuration word and restarts it through a separate poke strobe. The configuration word holds the escalation mode, a 16-bit length and two freeze enables. Reading the word back returns the live stage and the live 24-bit count.

The length forms the upper 16 bits of a 24-bit reload value whose low 8 bits are zero. The count moves one step every 2^PRE_LOG2 reference cycles, which is 1024 cycles by default. A stage therefore lasts length·2^18 reference cycles at the default setting. A zero length gives the shortest possible stage of one step.

Top module: `wdt_three_stage`

## Requirements
- R1: After reset, all outputs are low and `cfg_rdata` reads as zero.
- R2: Configuration word layout: mode in bits [1:0], stage in [3:2], length in [19:4], count in [43:20], debug-freeze enable in bit 44, global-freeze enable in bit 45; all other bits read as zero. On a write with a nonzero mode, the stage becomes 0 and the count becomes length·256. The stage and count bits of the written data are ignored.
- R3: While the watchdog is counting, the count drops by exactly one every 2^PRE_LOG2 cycles, counted from the write or poke.
- R4: The first expiry comes max(length·256, 1)·2^PRE_LOG2 cycles after the restarting write or poke. A length of 0 expires after a single step.
- R5: In mode 3, expiries raise `irq_first`, then `irq_second`, then a one-cycle `rst_req` pulse. The stage field reports the number of expiries so far. After each expiry except the last, the count reloads to length·256. The interrupts are levels, and `irq_second` is never high without `irq_first`.
- R6: Mode 1 stops after the first expiry, and mode 2 stops after the second. Once stopped, the count holds at 0 and no further interrupt or reset request appears. The stage never exceeds the mode.
- R7: A poke while the mode is nonzero does three things: it reloads the full count, returns the stage to 0 and drops both interrupts. A poke while the mode is 0 has no effect.
- R8: Writing a zero mode disables the watchdog. The count becomes 0, the stage becomes 0, both interrupts drop, and nothing fires afterwards.
- R9: When bit 44 is set and `dbg_halt` is high, the count and the prescaler freeze. When bit 44 is clear, `dbg_halt` is ignored.
- R10: When bit 45 is set and `glb_halt` is high, the count and the prescaler freeze. When bit 45 is clear, `glb_halt` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 64 | Configuration data to write |
| cfg_rdata | output | 64 | Live configuration, stage and count |
| poke_we | input | 1 | Restart strobe (write of any value to the poke register) |
| dbg_halt | input | 1 | Debug freeze request |
| glb_halt | input | 1 | Global freeze request |
| irq_first | output | 1 | Level interrupt after the first expiry |
| irq_second | output | 1 | Level interrupt after the second expiry |
| rst_req | output | 1 | One-cycle soft-reset request after the third expiry |

## Verification
The assertions assume that a configuration write takes priority over a poke in the same cycle. They also assume that the freeze inputs are held for whole cycles. The stimulus never pulses `cfg_we` and `poke_we` together, and it changes the freeze inputs only between clock edges. A reduced prescaler setting keeps each stage to a few thousand cycles, so that whole escalations fit in the run. The random trials draw the mode, the length and the poke time. Poke offsets are always shorter than one stage, so every expected expiry edge is computed from the last restart alone.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int WORD_W    = 64;
  localparam int MODE_W    = 2;
  localparam int STAGE_W   = 2;
  localparam int LEN_W     = 16;
  localparam int CNT_W     = 24;
  localparam int PAD_W     = CNT_W - LEN_W;
  localparam int MODE_LSB  = 0;
  localparam int STAGE_LSB = MODE_LSB + MODE_W;
  localparam int LEN_LSB   = STAGE_LSB + STAGE_W;
  localparam int CNT_LSB   = LEN_LSB + LEN_W;
  localparam int DFRZ_BIT  = CNT_LSB + CNT_W;
  localparam int GFRZ_BIT  = DFRZ_BIT + 1;
  localparam int USED_W    = GFRZ_BIT + 1;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_LOG2 = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  logic [PRE_LOG2-1:0] pre_q;

  assign tick = run && (pre_q == {PRE_LOG2{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pre_q <= '0;
    else if (clear) pre_q <= '0;
    else if (run)   pre_q <= pre_q + 1'b1;
  end

  AST_PRE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(pre_q)); // R9
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero,
  input  logic             load,
  input  logic             tick,
  input  logic             allow_reload,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  assign expire = tick && (cnt <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (zero)   cnt <= '0;
    else if (load)   cnt <= reload_val;
    else if (expire) cnt <= allow_reload ? reload_val : '0;
    else if (tick)   cnt <= cnt - 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !zero && !load && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - 1'b1)); // R3
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate #(
  parameter int STAGE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               expire,
  output logic [STAGE_W-1:0] stage,
  output logic               irq_first,
  output logic               irq_second,
  output logic               rst_req
);
  logic [STAGE_W-1:0] next_stage;
  assign next_stage = stage + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage      <= '0;
      irq_first  <= 1'b0;
      irq_second <= 1'b0;
      rst_req    <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (clear) begin
        stage      <= '0;
        irq_first  <= 1'b0;
        irq_second <= 1'b0;
      end else if (expire) begin
        stage <= next_stage;
        case (next_stage)
          STAGE_W'(1): irq_first  <= 1'b1;
          STAGE_W'(2): irq_second <= 1'b1;
          STAGE_W'(3): rst_req    <= 1'b1;
          default:     ;
        endcase
      end
    end
  end

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R5
  AST_IRQ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_second |-> irq_first); // R5
endmodule

// File: rtl/wdt_three_stage.sv
module wdt_three_stage
  import wdt_pkg::*;
#(
  parameter int PRE_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              poke_we,
  input  logic              dbg_halt,
  input  logic              glb_halt,
  output logic              irq_first,
  output logic              irq_second,
  output logic              rst_req
);
  logic [MODE_W-1:0]  mode_q;
  logic [LEN_W-1:0]   len_q;
  logic               dfrz_q, gfrz_q;
  logic [MODE_W-1:0]  wr_mode;
  logic [LEN_W-1:0]   wr_len;
  logic [STAGE_W-1:0] stage;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   reload_val;
  logic               poke_go, load, zero, clear_esc, halted, run;
  logic               tick, expire, allow_reload;
  logic               unused_wbits;

  assign wr_mode = cfg_wdata[MODE_LSB +: MODE_W];
  assign wr_len  = cfg_wdata[LEN_LSB +: LEN_W];
  assign unused_wbits = ^{cfg_wdata[WORD_W-1:USED_W], cfg_wdata[LEN_LSB-1:STAGE_LSB],
                          cfg_wdata[DFRZ_BIT-1:CNT_LSB]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      len_q  <= '0;
      dfrz_q <= 1'b0;
      gfrz_q <= 1'b0;
    end else if (cfg_we) begin
      mode_q <= wr_mode;
      len_q  <= wr_len;
      dfrz_q <= cfg_wdata[DFRZ_BIT];
      gfrz_q <= cfg_wdata[GFRZ_BIT];
    end
  end

  assign poke_go      = poke_we && !cfg_we && (mode_q != '0);
  assign zero         = cfg_we && (wr_mode == '0);
  assign load         = (cfg_we && (wr_mode != '0)) || poke_go;
  assign clear_esc    = cfg_we || poke_go;
  assign halted       = (dfrz_q && dbg_halt) || (gfrz_q && glb_halt);
  assign run          = (mode_q != '0) && (stage < mode_q) && !halted && !clear_esc;
  assign allow_reload = ({1'b0, stage} + 1'b1) < {1'b0, mode_q};
  assign reload_val   = cfg_we ? {wr_len, {PAD_W{1'b0}}} : {len_q, {PAD_W{1'b0}}};

  wdt_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(load || zero), .run(run), .tick(tick)
  );

  wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .zero(zero), .load(load), .tick(tick),
    .allow_reload(allow_reload), .reload_val(reload_val), .cnt(cnt), .expire(expire)
  );

  wdt_escalate #(.STAGE_W(STAGE_W)) u_esc (
    .clk(clk), .rst_n(rst_n), .clear(clear_esc), .expire(expire), .stage(stage),
    .irq_first(irq_first), .irq_second(irq_second), .rst_req(rst_req)
  );

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[MODE_LSB +: MODE_W]   = mode_q;
    cfg_rdata[STAGE_LSB +: STAGE_W] = stage;
    cfg_rdata[LEN_LSB +: LEN_W]     = len_q;
    cfg_rdata[CNT_LSB +: CNT_W]     = cnt;
    cfg_rdata[DFRZ_BIT]             = dfrz_q;
    cfg_rdata[GFRZ_BIT]             = gfrz_q;
  end

  AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stage <= mode_q); // R6
  AST_POKE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    poke_go |=> (cnt == {len_q, {PAD_W{1'b0}}}) && (stage == '0) && !irq_first); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == '0) |-> (!irq_first && !irq_second && cnt == '0)); // R8
  AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != '0 && dfrz_q && dbg_halt && !cfg_we && !poke_we) |=> $stable(cnt)); // R9
  AST_GLB_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != '0 && gfrz_q && glb_halt && !cfg_we && !poke_we) |=> $stable(cnt)); // R10
endmodule

// File: tb/wdt_three_stage_test.sv
module wdt_three_stage_test;
  localparam int P = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, poke_we = 1'b0, dbg_halt = 1'b0, glb_halt = 1'b0;
  logic [63:0] cfg_wdata = '0, cfg_rdata;
  logic irq_first, irq_second, rst_req;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_three_stage #(.PRE_LOG2(P)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .poke_we(poke_we), .dbg_halt(dbg_halt), .glb_halt(glb_halt),
    .irq_first(irq_first), .irq_second(irq_second), .rst_req(rst_req)
  );

  function automatic int stage_cycles(int len);
    int steps = len * 256;
    if (steps < 1) steps = 1;
    return steps * (1 << P);
  endfunction

  function automatic logic [63:0] cfg_word(int mode, int len, bit df, bit gf);
    logic [63:0] w = '0;
    w[1:0] = 2'(mode); w[19:4] = 16'(len); w[44] = df; w[45] = gf;
    return w;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_edges(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(logic [63:0] w);
    cfg_wdata = w; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic poke();
    poke_we = 1'b1;
    @(negedge clk);
    poke_we = 1'b0;
  endtask

  function automatic logic [23:0] rd_cnt(); return cfg_rdata[43:20]; endfunction
  function automatic logic [1:0] rd_stage(); return cfg_rdata[3:2]; endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int s, rst_seen;
    logic [63:0] w;
    void'($urandom(32'd1234));
    wait_edges(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", cfg_rdata, 64'h0);
    chk("R1 outs", {61'h0, irq_first, irq_second, rst_req}, 64'h0);

    // R2 layout, written stage/count bits ignored
    w = cfg_word(3, 1, 0, 0);
    w[3:2] = 2'b11; w[43:20] = 24'hABCDEF; w[63:50] = 14'h3FFF;
    write_cfg(w);
    chk("R2 readback", cfg_rdata, {20'h0, 24'd256, 16'd1, 2'd0, 2'd3});
    // R3 prescaled stepping
    wait_edges((1 << P) - 1);
    chk("R3 before step", 64'(rd_cnt()), 64'd256);
    wait_edges(1);
    chk("R3 first step", 64'(rd_cnt()), 64'd255);
    wait_edges(1 << P);
    chk("R3 second step", 64'(rd_cnt()), 64'd254);

    // R5 full escalation in mode 3
    s = stage_cycles(1);
    write_cfg(cfg_word(3, 1, 0, 0));
    wait_edges(s - 1);
    chk("R4 no early irq", 64'(irq_first), 64'd0);
    wait_edges(1);
    chk("R4 irq_first on time", 64'(irq_first), 64'd1);
    chk("R5 stage 1", 64'(rd_stage()), 64'd1);
    chk("R5 reload", 64'(rd_cnt()), 64'd256);
    wait_edges(s - 1);
    chk("R5 no early irq2", 64'(irq_second), 64'd0);
    wait_edges(1);
    chk("R5 irq_second", 64'({irq_first, irq_second}), 64'd3);
    wait_edges(s - 1);
    chk("R5 no early rst", 64'(rst_req), 64'd0);
    wait_edges(1);
    chk("R5 rst pulse", 64'(rst_req), 64'd1);
    chk("R5 stage 3", 64'(rd_stage()), 64'd3);
    wait_edges(1);
    chk("R5 rst one cycle", 64'(rst_req), 64'd0);
    wait_edges(40);
    chk("R5 count parked", 64'(rd_cnt()), 64'd0);

    // R7 poke clears and reloads
    poke();
    chk("R7 poke", {cfg_rdata[43:0], 2'b00, irq_first, irq_second},
        {24'd256, 16'd1, 2'd0, 2'd3, 4'b0000});

    // R6 mode 1 and mode 2 stop
    write_cfg(cfg_word(1, 1, 0, 0));
    wait_edges(s);
    chk("R6 mode1 irq1", 64'(irq_first), 64'd1);
    wait_edges(2 * s);
    chk("R6 mode1 stops", {62'h0, irq_second, 1'b0} | 64'(rd_stage()), 64'd1);
    chk("R6 mode1 count 0", 64'(rd_cnt()), 64'd0);
    write_cfg(cfg_word(2, 1, 0, 0));
    rst_seen = 0;
    for (int i = 0; i < 4 * s; i++) begin
      @(negedge clk);
      if (rst_req) rst_seen++;
    end
    chk("R6 mode2 irq2 no reset", {62'h0, irq_second, 1'b0} | 64'(rst_seen), 64'd2);
    chk("R6 mode2 stage", 64'(rd_stage()), 64'd2);

    // R8 disable
    write_cfg(64'h0);
    chk("R8 disabled", {cfg_rdata[61:0], irq_first, irq_second}, 64'h0);
    wait_edges(2 * s);
    chk("R8 silent", 64'({irq_first, irq_second, rst_req}), 64'd0);
    poke();
    chk("R7 poke while off", 64'(rd_cnt()), 64'd0);

    // R4 zero length boundary
    write_cfg(cfg_word(3, 0, 0, 0));
    wait_edges((1 << P) - 1);
    chk("R4 len0 early", 64'(irq_first), 64'd0);
    wait_edges(1);
    chk("R4 len0 expiry", 64'(irq_first), 64'd1);

    // R9 debug freeze
    dbg_halt = 1'b1;
    write_cfg(cfg_word(3, 1, 1, 0));
    wait_edges(50);
    chk("R9 frozen", 64'(rd_cnt()), 64'd256);
    write_cfg(cfg_word(3, 1, 0, 0));
    wait_edges(2 << P);
    chk("R9 ignored", 64'(rd_cnt()), 64'd254);
    dbg_halt = 1'b0;
    // R10 global freeze
    glb_halt = 1'b1;
    write_cfg(cfg_word(3, 1, 0, 1));
    wait_edges(50);
    chk("R10 frozen", 64'(rd_cnt()), 64'd256);
    glb_halt = 1'b0;
    wait_edges(1 << P);
    chk("R10 resumes", 64'(rd_cnt()), 64'd255);
    glb_halt = 1'b1;
    write_cfg(cfg_word(3, 1, 1, 0));
    wait_edges(1 << P);
    chk("R10 ignored", 64'(rd_cnt()), 64'd255);
    glb_halt = 1'b0;

    // Random trials: mode, length, poke time (R4 R6 R7)
    for (int t = 0; t < 8; t++) begin
      int mode = 1 + int'($urandom % 3);
      int len = 1 + int'($urandom % 2);
      int st = stage_cycles(len);
      int r = int'($urandom % (st - 2));
      write_cfg(cfg_word(mode, len, 0, 0));
      wait_edges(r);
      poke();
      wait_edges(st - 1);
      chk("R7 rand no early", 64'(irq_first), 64'd0);
      wait_edges(1);
      chk("R4 rand expiry", 64'(irq_first), 64'd1);
      wait_edges(st);
      chk("R6 rand irq2", 64'(irq_second), 64'(mode >= 2));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule